// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block sits beside the address path of a 16-bit processor core and turns each logical reference into the address that leaves the core. It holds the four 16-bit segment bases: code, data, stack and extra. The core reloads any of them through a simple write port. For a memory request, the block picks one base. The pick follows the access class the core reports, unless a valid segment override takes precedence for the classes that accept one. The block then forms the 20-bit physical address as the base times sixteen plus the 16-bit offset, modulo 1 Mbyte.

I/O requests take a separate path that does not use segments. A short port number from the instruction is zero-extended. A long port number is taken from the DX value the core supplies. The result is placed in the low 16 address bits, and a flag is raised when the port falls in the reserved window 00F8h to 00FFh. Every result is registered and appears one clock after the request, together with a valid strobe and the code of the segment that was used.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset, the code base is FFFFh, the data, stack and extra bases are 0000h, and out_valid is low.
- R2: A request presented with req_valid high produces out_valid high on the next clock edge. For memory classes, out_addr equals (base * 16 + offset) taken modulo 2^20.
- R3: Any carry out of bit 19 of the base-plus-offset sum is dropped. For example, base FFFFh with offset FFFFh yields 0FFEFh.
- R4: Class 0 (instruction fetch) always uses the code base (segment code 01), whatever the override inputs hold.
- R5: Class 1 (push/pop) always uses the stack base (code 10) and ignores the override. Class 2 (BP-based reference) uses the stack base when no override is valid.
- R6: Class 3 (string destination indexed by DI) always uses the extra base (code 00), whatever the override inputs hold.
- R7: Class 4 (ordinary data) and the unused class code 7 use the data base (code 11) when no override is valid.
- R8: For classes 2, 4 and 7, a valid override selects the base named by ovr_seg: 00 extra, 01 code, 10 stack, 11 data.
- R9: A segment write (wr_sel using the R8 codes) takes effect at the clock edge. A request in the same cycle uses the previous value, and the next request uses the new one.
- R10: Class 5 (short I/O) yields out_addr equal to the zero-extended 8-bit io_imm, with bits 19..8 low and out_is_io high.
- R11: Class 6 (long I/O) yields out_addr equal to io_dx in bits 15..0, with bits 19..16 low and out_is_io high.
- R12: out_rsvd is high exactly for I/O results whose port lies in 00F8h..00FFh. It is never high for memory results.
- R13: out_seg reports the code of the base used, and reads 00 for I/O results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment register to write (00 extra, 01 code, 10 stack, 11 data) |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Request strobe |
| req_class | input | 3 | Access class (0 fetch, 1 push/pop, 2 BP-based, 3 string dest, 4 data, 5 short I/O, 6 long I/O, 7 data) |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| io_imm | input | 8 | Short port number from the instruction |
| io_dx | input | 16 | Long port number from DX |
| out_valid | output | 1 | Result valid, one cycle after req_valid |
| out_addr | output | 20 | Physical or port address |
| out_seg | output | 2 | Segment code used (00 for I/O) |
| out_is_io | output | 1 | Result is an I/O port address |
| out_rsvd | output | 1 | I/O port lies in the reserved window |

## Verification
A segment register write and an address request that reads that same register can arrive in one cycle. The bench provokes this by raising wr_en and req_valid on the same falling edge, with a data-class request aimed at the register being rewritten. The result is judged correct when the output seen after the next rising edge carries the address built from the old base. An identical request on the following cycle must then carry the new base. Around this case, every class is swept against every override setting and several offsets, and both I/O paths are swept across the reserved window.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W_D  = 16;
    localparam int OFF_W_D  = 16;
    localparam int SHIFT_D  = 4;
    localparam int IMM_W_D  = 8;
    localparam int PORT_W_D = 16;
    localparam int NSEG_D   = 4;

    // segment codes; also the override and write-select encoding
    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        ACC_FETCH  = 3'd0,
        ACC_STACK  = 3'd1,
        ACC_BPREF  = 3'd2,
        ACC_STRDST = 3'd3,
        ACC_DATA   = 3'd4,
        ACC_IO8    = 3'd5,
        ACC_IO16   = 3'd6,
        ACC_SPARE  = 3'd7
    } acc_class_e;

    localparam logic [15:0] RSVD_PORT_LO = 16'h00F8;
    localparam logic [15:0] RSVD_PORT_HI = 16'h00FF;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = SEG_W_D,
    parameter int NSEG   = NSEG_D,
    parameter int SEL_W  = $clog2(NSEG),
    parameter int CS_IDX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [NSEG-1:0][SEG_W-1:0] bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                bank[i] <= (i == CS_IDX) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
            end
        end else if (wr_en) begin
            for (int i = 0; i < NSEG; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    bank[i] <= wr_data;
                end
            end
        end
    end

    // read is combinational from the stored value, so a same-cycle write is not seen
    assign rd_data = bank[rd_sel];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bank[$past(wr_sel)] == $past(wr_data)); // R9

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  acc_class_e cls,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_seg,
    output seg_id_e    seg_id,
    output logic       is_io,
    output logic       io_wide
);

    always_comb begin
        seg_id  = SEG_DS;
        is_io   = 1'b0;
        io_wide = 1'b0;
        unique case (cls)
            ACC_FETCH:  seg_id = SEG_CS;
            ACC_STACK:  seg_id = SEG_SS;
            ACC_BPREF:  seg_id = ovr_valid ? seg_id_e'(ovr_seg) : SEG_SS;
            ACC_STRDST: seg_id = SEG_ES;
            ACC_DATA,
            ACC_SPARE:  seg_id = ovr_valid ? seg_id_e'(ovr_seg) : SEG_DS;
            ACC_IO8: begin
                seg_id = SEG_ES;
                is_io  = 1'b1;
            end
            ACC_IO16: begin
                seg_id  = SEG_ES;
                is_io   = 1'b1;
                io_wide = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = SEG_W_D,
    parameter int OFF_W  = OFF_W_D,
    parameter int SHIFT  = SHIFT_D,
    parameter int IMM_W  = IMM_W_D,
    parameter int PORT_W = PORT_W_D,
    parameter int PA_W   = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_io,
    input  logic              io_wide,
    input  logic [IMM_W-1:0]  io_imm,
    input  logic [PORT_W-1:0] io_dx,
    output logic [PA_W-1:0]   addr,
    output logic              rsvd
);

    logic [PA_W-1:0]   base_sh;
    logic [PA_W-1:0]   off_ext;
    logic [PA_W-1:0]   mem_addr;
    logic [PORT_W-1:0] port;

    assign base_sh  = {seg_base, {SHIFT{1'b0}}};
    assign off_ext  = PA_W'(offset);
    // sum is kept at PA_W bits: the carry out of the top bit is dropped
    assign mem_addr = base_sh + off_ext;

    assign port = io_wide ? io_dx : PORT_W'(io_imm);

    always_comb begin
        if (is_io) begin
            addr = PA_W'(port);
            rsvd = (port >= PORT_W'(RSVD_PORT_LO)) && (port <= PORT_W'(RSVD_PORT_HI));
        end else begin
            addr = mem_addr;
            rsvd = 1'b0;
        end
    end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = SEG_W_D,
    parameter int OFF_W  = OFF_W_D,
    parameter int SHIFT  = SHIFT_D,
    parameter int IMM_W  = IMM_W_D,
    parameter int PORT_W = PORT_W_D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [SEG_W-1:0]        wr_data,
    input  logic                    req_valid,
    input  logic [2:0]              req_class,
    input  logic [OFF_W-1:0]        req_offset,
    input  logic                    ovr_valid,
    input  logic [1:0]              ovr_seg,
    input  logic [IMM_W-1:0]        io_imm,
    input  logic [PORT_W-1:0]       io_dx,
    output logic                    out_valid,
    output logic [SEG_W+SHIFT-1:0]  out_addr,
    output logic [1:0]              out_seg,
    output logic                    out_is_io,
    output logic                    out_rsvd
);

    localparam int PA_W = SEG_W + SHIFT;

    seg_id_e           sel_id;
    logic              sel_io;
    logic              sel_wide;
    logic [SEG_W-1:0]  seg_val;
    logic [PA_W-1:0]   nxt_addr;
    logic              nxt_rsvd;

    seg_select u_sel (
        .cls       (acc_class_e'(req_class)),
        .ovr_valid (ovr_valid),
        .ovr_seg   (ovr_seg),
        .seg_id    (sel_id),
        .is_io     (sel_io),
        .io_wide   (sel_wide)
    );

    seg_regfile #(
        .SEG_W  (SEG_W),
        .NSEG   (NSEG_D),
        .SEL_W  (2),
        .CS_IDX (int'(SEG_CS))
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (sel_id),
        .rd_data (seg_val)
    );

    seg_addr_calc #(
        .SEG_W  (SEG_W),
        .OFF_W  (OFF_W),
        .SHIFT  (SHIFT),
        .IMM_W  (IMM_W),
        .PORT_W (PORT_W),
        .PA_W   (PA_W)
    ) u_calc (
        .seg_base (seg_val),
        .offset   (req_offset),
        .is_io    (sel_io),
        .io_wide  (sel_wide),
        .io_imm   (io_imm),
        .io_dx    (io_dx),
        .addr     (nxt_addr),
        .rsvd     (nxt_rsvd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_seg   <= '0;
            out_is_io <= 1'b0;
            out_rsvd  <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_addr  <= nxt_addr;
                out_seg   <= sel_id;
                out_is_io <= sel_io;
                out_rsvd  <= nxt_rsvd;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R2
    AST_FETCH_CODE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == ACC_FETCH) |=> (out_seg == SEG_CS && !out_is_io)); // R4
    AST_PUSHPOP_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == ACC_STACK) |=> (out_seg == SEG_SS)); // R5
    AST_STRDST_EXTRA_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == ACC_STRDST) |=> (out_seg == SEG_ES)); // R6
    AST_OVERRIDE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_valid && req_class == ACC_DATA) |=> (out_seg == $past(ovr_seg))); // R8
    AST_IO8_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == ACC_IO8) |=> (out_addr[PA_W-1:IMM_W] == '0)); // R10
    AST_IO_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_io) |-> (out_addr[PA_W-1:PORT_W] == '0)); // R11
    AST_RSVD_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_rsvd |-> out_is_io); // R12

endmodule

// File: tb/seg_addr_unit_tb.sv
module seg_addr_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_class = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [7:0]  io_imm = '0;
    logic [15:0] io_dx = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [1:0]  out_seg;
    logic        out_is_io;
    logic        out_rsvd;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [15:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_class(req_class), .req_offset(req_offset),
        .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .io_imm(io_imm), .io_dx(io_dx),
        .out_valid(out_valid), .out_addr(out_addr), .out_seg(out_seg),
        .out_is_io(out_is_io), .out_rsvd(out_rsvd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_seg(input int cls, input bit ov, input logic [1:0] oc);
        case (cls)
            0: return 2'd1;
            1: return 2'd2;
            2: return ov ? oc : 2'd2;
            3: return 2'd0;
            default: return ov ? oc : 2'd3;
        endcase
    endfunction

    function automatic logic [19:0] exp_addr(input logic [15:0] base, input logic [15:0] off);
        logic [31:0] s;
        s = ({16'h0, base} << 4) + {16'h0, off};
        return s[19:0];
    endfunction

    task automatic seg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        model[sel] = data;
    endtask

    task automatic issue(input int cls, input logic [15:0] off, input bit ov, input logic [1:0] oc,
                         input logic [7:0] imm, input logic [15:0] dx);
        @(negedge clk);
        req_valid = 1'b1; req_class = 3'(cls); req_offset = off;
        ovr_valid = ov; ovr_seg = oc; io_imm = imm; io_dx = dx;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic mem_check(input int cls, input logic [15:0] off, input bit ov, input logic [1:0] oc,
                             input string req);
        logic [1:0] s;
        s = exp_seg(cls, ov, oc);
        issue(cls, off, ov, oc, 8'hF9, 16'h00FA);
        chk(out_valid === 1'b1, {req, " valid R2"}, 32'(out_valid), 32'd1);
        chk(out_addr === exp_addr(model[s], off), {req, " addr"}, 32'(out_addr), 32'(exp_addr(model[s], off)));
        chk(out_seg === s, {req, " seg R13"}, 32'(out_seg), 32'(s));
        chk(out_rsvd === 1'b0 && out_is_io === 1'b0, {req, " memory not io R12"}, 32'({out_is_io, out_rsvd}), 32'd0);
    endtask

    task automatic io_check(input bit wide, input logic [15:0] port);
        logic [15:0] p;
        bit r;
        p = wide ? port : {8'h00, port[7:0]};
        r = (p >= 16'h00F8) && (p <= 16'h00FF);
        if (wide) issue(6, 16'hFFFF, 1'b1, 2'd3, ~port[7:0], port);
        else      issue(5, 16'hFFFF, 1'b1, 2'd3, port[7:0], 16'hFFFF);
        chk(out_addr === {4'h0, p}, wide ? "R11 long io addr" : "R10 short io addr", 32'(out_addr), 32'(p));
        chk(out_is_io === 1'b1 && out_seg === 2'd0, "R13 io seg code", 32'({out_is_io, out_seg}), 32'h4);
        chk(out_rsvd === r, "R12 reserved flag", 32'(out_rsvd), 32'(r));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        model[0] = 16'h0000; model[1] = 16'hFFFF; model[2] = 16'h0000; model[3] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid low after reset", 32'(out_valid), 32'd0);
        mem_check(0, 16'h0000, 1'b0, 2'd0, "R1 code base reset");
        mem_check(4, 16'h0010, 1'b0, 2'd0, "R1 data base reset");
        mem_check(1, 16'h0020, 1'b0, 2'd0, "R1 stack base reset");
        mem_check(3, 16'h0030, 1'b0, 2'd0, "R1 extra base reset");
        @(negedge clk);
        chk(out_valid === 1'b0, "R2 valid drops without request", 32'(out_valid), 32'd0);

        seg_write(2'd0, 16'h1234);
        seg_write(2'd1, 16'hF000);
        seg_write(2'd2, 16'h8000);
        seg_write(2'd3, 16'hABCD);

        // R4 R5 R6 R7 R8 sweep: every memory class against every override setting
        for (int cls = 0; cls < 8; cls++) begin
            if (cls == 5 || cls == 6) continue;
            for (int ov = 0; ov < 2; ov++) begin
                for (int oc = 0; oc < 4; oc++) begin
                    if (ov == 0 && oc != 0) continue;
                    mem_check(cls, 16'h0000, bit'(ov), 2'(oc), "R4 R5 R6 R7 R8 sweep");
                    mem_check(cls, 16'hFFFF, bit'(ov), 2'(oc), "R2 R3 sweep");
                    mem_check(cls, 16'h1357, bit'(ov), 2'(oc), "R2 sweep");
                    mem_check(cls, 16'h8001, bit'(ov), 2'(oc), "R2 sweep");
                end
            end
        end

        // R3 wrap past 1 Mbyte
        seg_write(2'd3, 16'hFFFF);
        issue(4, 16'hFFFF, 1'b0, 2'd0, 8'h00, 16'h0000);
        chk(out_addr === 20'h0FFEF, "R3 carry dropped", 32'(out_addr), 32'h0FFEF);

        // R9 write and request in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h2000;
        req_valid = 1'b1; req_class = 3'd4; req_offset = 16'h0005; ovr_valid = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk(out_addr === exp_addr(16'hFFFF, 16'h0005), "R9 old base same cycle",
            32'(out_addr), 32'(exp_addr(16'hFFFF, 16'h0005)));
        model[3] = 16'h2000;
        issue(4, 16'h0005, 1'b0, 2'd0, 8'h00, 16'h0000);
        chk(out_addr === 20'h20005, "R9 new base next cycle", 32'(out_addr), 32'h20005);

        // R10 R12 short I/O over every port number
        for (int p = 0; p < 256; p++) io_check(1'b0, 16'(p));
        // R11 R12 long I/O around the reserved window and across the range
        for (int p = 16'h00F0; p < 16'h0108; p++) io_check(1'b1, 16'(p));
        for (int k = 0; k < 256; k++) io_check(1'b1, 16'(k * 16'h0101));
        io_check(1'b1, 16'h01F8);
        io_check(1'b1, 16'hF8F8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule